// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers interrupt requests from 32 priority slots and picks the highest-priority request that is eligible. It presents that request to the CPU as a slot number and a 16-bit vector address. Slot `s` owns the vector word at `0xFFC0 + 2*s`. Slot 31 (address `0xFFFE`) is the restart slot and has the highest priority.

There are three kinds of request:

- **Restart requests** are never masked.
- **Slot 30** is a non-maskable group. Each source in it has its own enable bit, but the global interrupt enable has no effect on it.
- **Slots 0 to 29** are ordinary requests. They count only while the global enable is high.

The block holds four byte-wide system registers at byte addresses 0 to 3: two enable registers and two flag registers. It also checks two things that can stop normal start-up. An instruction fetch from an address outside the legal regions forces a restart. A restart vector that reads all ones puts the device into its deepest sleep instead of a fetch.

When the CPU takes a request, the block returns a one-cycle acknowledge strobe to the slot that won.

Top module: `ivc_top`

## Requirements
- R1: Synchronous reset `rst` (power-up) leaves both enable registers at 0x00, flag register 1 at 0x06 (power-on bit 2 and oscillator-fault bit 1 set), flag register 2 at 0x0A, and the restart slot pending, so `int_vector` reads 0xFFFE.
- R2: `int_pending` is high when any slot is eligible. `int_slot` then gives the highest eligible slot and `int_vector` gives `0xFFC0 + 2*int_slot`. All of this is combinational from the current inputs and the registered state.
- R3: External lines `irq_lines[i]` (slots 0 to 29) and the system requests of slots 26, 23 and 22 are eligible only while `gie` is 1.
- R4: Slot 30 is eligible, whatever the value of `gie`, when any of these holds: (flag1 bit 4 and enable1 bit 4), (flag1 bit 1 and enable1 bit 1), or (`acc_viol` and enable1 bit 5).
- R5: Slot 26 requests when flag1 bit 0 and enable1 bit 0 are both set and `wdt_interval` is 1. In watchdog mode (`wdt_interval` = 0) enable1 bit 0 has no effect.
- R6: Slot 23 (receive) requests from (flag2 bit 0 and enable2 bit 0) or (flag2 bit 2 and enable2 bit 2). Slot 22 (transmit) requests from the same pairings on bits 1 and 3.
- R7: When `int_take` is high while `int_pending` is high, `irq_ack` shows a one-hot strobe on the winning slot in the next cycle, for that cycle only. Taking slot 26 clears flag1 bit 0. Taking slot 31 clears the pending restart. Flags of slots 30, 23 and 22 are left unchanged.
- R8: `reg_addr` selects register 0 = enable1 (bits 0, 1, 4, 5 implemented), 1 = enable2 (bits 3:0), 2 = flag1 (bits 4:0) or 3 = flag2 (bits 3:0). `reg_rdata` reads the selected register. A write with `reg_we` stores only the implemented bits, and the other bits read 0.
- R9: A restart cause raises `sys_reset_req` for one cycle, starting the cycle after the cause. The causes are `rst_pin_evt`, `wdt_expire` with `wdt_interval` = 0, `key_viol`, and an illegal fetch. The same edge clears both enable registers, sets flag1 bit 1, sets flag2 to 0x0A, and marks the restart slot pending. `rst_pin_evt` also sets flag1 bit 3 and clears flag1 bit 0. `wdt_expire` and `key_viol` set flag1 bit 0.
- R10: A fetch with `fetch_valid` is illegal unless its address lies in one of these ranges: 0x0200 to 0x03FF, 0x1000 to 0x10FF, or 0xC000 to 0xFFFF.
- R11: `rvec_valid` with `rvec_data` = 0xFFFF sets `deep_sleep` from the next cycle. While `deep_sleep` is set, `int_pending` stays 0. A restart cause or `rst` clears `deep_sleep`.
- R12: Hardware set events take priority over a software write in the same cycle. These events are `ser_flag_set[3:0]` into flag2 bits 3:0, `nmi_pin_evt` into flag1 bit 4 and `osc_fault_evt` into flag1 bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| gie | input | 1 | Global interrupt enable from the CPU status |
| irq_lines | input | 30 | Level requests for slots 0 to 29 |
| wdt_interval | input | 1 | Watchdog runs as an interval timer |
| wdt_expire | input | 1 | Watchdog interval elapsed (pulse) |
| rst_pin_evt | input | 1 | External reset pin event (pulse) |
| key_viol | input | 1 | Flash key violation (pulse) |
| nmi_pin_evt | input | 1 | NMI pin edge (pulse) |
| osc_fault_evt | input | 1 | Oscillator fault detected (pulse) |
| acc_viol | input | 1 | Flash access violation flag (level) |
| ser_flag_set | input | 4 | Serial receive/transmit flag set pulses |
| fetch_valid | input | 1 | CPU instruction fetch in this cycle |
| fetch_addr | input | 16 | Fetch address |
| rvec_valid | input | 1 | Restart vector word read after start-up |
| rvec_data | input | 16 | Restart vector word value |
| reg_addr | input | 2 | System register select |
| reg_we | input | 1 | System register write strobe |
| reg_wdata | input | 8 | System register write data |
| reg_rdata | output | 8 | System register read data |
| int_take | input | 1 | CPU takes the presented request |
| int_pending | output | 1 | An eligible request exists |
| int_slot | output | 5 | Winning slot number |
| int_vector | output | 16 | Vector word address of the winner |
| irq_ack | output | 32 | One-cycle acknowledge, one-hot by slot |
| sys_reset_req | output | 1 | Restart request to the system |
| deep_sleep | output | 1 | Erased restart vector detected |

## Verification
The embedded properties watch these behaviours on every cycle:

- the acknowledge strobe stays one-hot and only follows an accepted request;
- no ordinary slot wins while the global enable is low;
- a restart request always comes with cleared enables;
- a low-range fetch restarts;
- an auto-cleared flag actually drops;
- enable writes land masked;
- a pin restart sets its flag;
- deep sleep begins only after an erased vector word.

Only the bench's scenarios can show some things: the exact vector chosen among competing slots, the register values after each class of restart, the boundary addresses of every legal fetch range, and that multi-source flags survive acknowledgement.

// File: rtl/ivc_pkg.sv
package ivc_pkg;

    localparam int SLOTS      = 32;
    localparam int PW         = $clog2(SLOTS);
    localparam int EXT_SLOTS  = SLOTS - 2;

    localparam int SLOT_RESET = SLOTS - 1;
    localparam int SLOT_NMI   = SLOTS - 2;
    localparam int SLOT_WDT   = 26;
    localparam int SLOT_SRX   = 23;
    localparam int SLOT_STX   = 22;

    typedef logic [15:0]   addr_t;
    typedef logic [PW-1:0] slot_t;

    localparam addr_t VEC_BASE = addr_t'(32'h0001_0000 - 2 * SLOTS);

    localparam logic [SLOTS-1:0] NONMASK = (SLOTS'(1) << SLOT_RESET) | (SLOTS'(1) << SLOT_NMI);

    // enable register 1 bit positions
    localparam int EN1_WDT = 0;
    localparam int EN1_OSC = 1;
    localparam int EN1_NMI = 4;
    localparam int EN1_ACC = 5;
    // flag register 1 bit positions
    localparam int FL1_WDT = 0;
    localparam int FL1_OSC = 1;
    localparam int FL1_POR = 2;
    localparam int FL1_RST = 3;
    localparam int FL1_NMI = 4;

    localparam logic [7:0] EN1_MASK = 8'h33;
    localparam logic [7:0] EN2_MASK = 8'h0F;
    localparam logic [7:0] FL1_MASK = 8'h1F;
    localparam logic [7:0] FL2_MASK = 8'h0F;
    localparam logic [7:0] FL1_POR_VAL = 8'h06;
    localparam logic [7:0] FL2_PUC_VAL = 8'h0A;

    typedef enum logic [1:0] {
        REG_EN1 = 2'd0,
        REG_EN2 = 2'd1,
        REG_FL1 = 2'd2,
        REG_FL2 = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [7:0] en1;
        logic [7:0] en2;
        logic [7:0] fl1;
        logic [7:0] fl2;
    } sysregs_t;

    typedef struct packed {
        logic pin_rst;
        logic wdt_expire;
        logic key_viol;
        logic bad_fetch;
        logic nmi_pin;
        logic osc_fault;
    } sys_evt_t;

    typedef struct packed {
        logic  valid;
        slot_t slot;
        addr_t vec;
    } grant_t;

    function automatic addr_t slot_vector(input slot_t s);
        return VEC_BASE + addr_t'({s, 1'b0});
    endfunction

endpackage

// File: rtl/ivc_fetch_guard.sv
module ivc_fetch_guard
    import ivc_pkg::*;
#(
    parameter addr_t RAM_LO  = 16'h0200,
    parameter addr_t RAM_HI  = 16'h03FF,
    parameter addr_t INFO_LO = 16'h1000,
    parameter addr_t INFO_HI = 16'h10FF,
    parameter addr_t CODE_LO = 16'hC000
) (
    input  logic  fetch_valid,
    input  addr_t fetch_addr,
    output logic  illegal
);

    logic in_ram, in_info, in_code;

    always_comb begin
        in_ram  = (fetch_addr >= RAM_LO)  && (fetch_addr <= RAM_HI);
        in_info = (fetch_addr >= INFO_LO) && (fetch_addr <= INFO_HI);
        in_code = (fetch_addr >= CODE_LO);
        illegal = fetch_valid && !(in_ram || in_info || in_code);
    end

endmodule

// File: rtl/ivc_sysregs.sv
module ivc_sysregs
    import ivc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  sys_evt_t   evt,
    input  logic       wdt_interval,
    input  logic [3:0] ser_set,
    input  logic       wr_en,
    input  reg_sel_e   sel,
    input  logic [7:0] wr_data,
    input  logic       wdt_ack,
    output sysregs_t   regs,
    output logic [7:0] rd_data,
    output logic       puc_now,
    output logic       puc_q
);

    sysregs_t nxt;

    assign puc_now = evt.pin_rst | (evt.wdt_expire & ~wdt_interval)
                   | evt.key_viol | evt.bad_fetch;

    always_comb begin
        nxt = regs;
        if (wr_en) begin
            unique case (sel)
                REG_EN1: nxt.en1 = wr_data & EN1_MASK;
                REG_EN2: nxt.en2 = wr_data & EN2_MASK;
                REG_FL1: nxt.fl1 = wr_data & FL1_MASK;
                REG_FL2: nxt.fl2 = wr_data & FL2_MASK;
            endcase
        end
        if (wdt_ack)                         nxt.fl1[FL1_WDT] = 1'b0;
        if (evt.pin_rst)                     nxt.fl1[FL1_WDT] = 1'b0;
        if (evt.wdt_expire || evt.key_viol)  nxt.fl1[FL1_WDT] = 1'b1;
        if (evt.nmi_pin)                     nxt.fl1[FL1_NMI] = 1'b1;
        if (evt.osc_fault)                   nxt.fl1[FL1_OSC] = 1'b1;
        if (evt.pin_rst)                     nxt.fl1[FL1_RST] = 1'b1;
        nxt.fl2 = nxt.fl2 | {4'b0000, ser_set};
        if (puc_now) begin
            nxt.en1          = '0;
            nxt.en2          = '0;
            nxt.fl1[FL1_OSC] = 1'b1;
            nxt.fl2          = FL2_PUC_VAL | {4'b0000, ser_set};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.en1 <= '0;
            regs.en2 <= '0;
            regs.fl1 <= FL1_POR_VAL;
            regs.fl2 <= FL2_PUC_VAL;
            puc_q    <= 1'b0;
        end else begin
            regs  <= nxt;
            puc_q <= puc_now;
        end
    end

    always_comb begin
        unique case (sel)
            REG_EN1: rd_data = regs.en1;
            REG_EN2: rd_data = regs.en2;
            REG_FL1: rd_data = regs.fl1;
            REG_FL2: rd_data = regs.fl2;
        endcase
    end

    // R7
    wdt_autoclr_chk: assert property (@(posedge clk) disable iff (rst)
        (wdt_ack && !evt.wdt_expire && !evt.key_viol) |=> !regs.fl1[FL1_WDT]);

    // R9
    pin_flag_chk: assert property (@(posedge clk) disable iff (rst)
        evt.pin_rst |=> regs.fl1[FL1_RST]);

    // R8
    en2_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == REG_EN2 && !puc_now) |=> regs.en2 == $past(wr_data & EN2_MASK));

endmodule

// File: rtl/ivc_arbiter.sv
module ivc_arbiter
    import ivc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SLOTS-1:0] raw_req,
    input  logic             gie,
    output grant_t           grant
);

    logic [SLOTS-1:0] elig;

    for (genvar i = 0; i < SLOTS; i++) begin : g_gate
        if (NONMASK[i]) begin : g_nm
            assign elig[i] = raw_req[i];
        end else begin : g_mk
            assign elig[i] = raw_req[i] & gie;
        end
    end

    always_comb begin
        grant.valid = 1'b0;
        grant.slot  = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (elig[i]) begin
                grant.valid = 1'b1;
                grant.slot  = slot_t'(i);
            end
        end
        grant.vec = slot_vector(grant.slot);
    end

    // R3
    gie_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (grant.valid && !gie) |-> (grant.slot >= slot_t'(SLOT_NMI)));

endmodule

// File: rtl/ivc_top.sv
module ivc_top
    import ivc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 gie,
    input  logic [EXT_SLOTS-1:0] irq_lines,
    input  logic                 wdt_interval,
    input  logic                 wdt_expire,
    input  logic                 rst_pin_evt,
    input  logic                 key_viol,
    input  logic                 nmi_pin_evt,
    input  logic                 osc_fault_evt,
    input  logic                 acc_viol,
    input  logic [3:0]           ser_flag_set,
    input  logic                 fetch_valid,
    input  logic [15:0]          fetch_addr,
    input  logic                 rvec_valid,
    input  logic [15:0]          rvec_data,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_we,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 int_take,
    output logic                 int_pending,
    output logic [PW-1:0]        int_slot,
    output logic [15:0]          int_vector,
    output logic [SLOTS-1:0]     irq_ack,
    output logic                 sys_reset_req,
    output logic                 deep_sleep
);

    sys_evt_t         evt;
    sysregs_t         regs;
    grant_t           grant;
    logic             bad_fetch, puc_now, take_ok, wdt_ack;
    logic             rpend_q, halt_q;
    logic [SLOTS-1:0] raw_req, ack_q;
    logic             nmi_req, wdt_req, srx_req, stx_req;

    ivc_fetch_guard u_guard (
        .fetch_valid (fetch_valid),
        .fetch_addr  (fetch_addr),
        .illegal     (bad_fetch)
    );

    assign evt = '{pin_rst:    rst_pin_evt,
                   wdt_expire: wdt_expire,
                   key_viol:   key_viol,
                   bad_fetch:  bad_fetch,
                   nmi_pin:    nmi_pin_evt,
                   osc_fault:  osc_fault_evt};

    ivc_sysregs u_regs (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .wdt_interval (wdt_interval),
        .ser_set      (ser_flag_set),
        .wr_en        (reg_we),
        .sel          (reg_sel_e'(reg_addr)),
        .wr_data      (reg_wdata),
        .wdt_ack      (wdt_ack),
        .regs         (regs),
        .rd_data      (reg_rdata),
        .puc_now      (puc_now),
        .puc_q        (sys_reset_req)
    );

    always_comb begin
        nmi_req = (regs.fl1[FL1_NMI] & regs.en1[EN1_NMI])
                | (regs.fl1[FL1_OSC] & regs.en1[EN1_OSC])
                | (acc_viol          & regs.en1[EN1_ACC]);
        wdt_req = regs.fl1[FL1_WDT] & regs.en1[EN1_WDT] & wdt_interval;
        srx_req = (regs.fl2[0] & regs.en2[0]) | (regs.fl2[2] & regs.en2[2]);
        stx_req = (regs.fl2[1] & regs.en2[1]) | (regs.fl2[3] & regs.en2[3]);

        raw_req                  = '0;
        raw_req[EXT_SLOTS-1:0]   = irq_lines;
        raw_req[SLOT_WDT]        = raw_req[SLOT_WDT] | wdt_req;
        raw_req[SLOT_SRX]        = raw_req[SLOT_SRX] | srx_req;
        raw_req[SLOT_STX]        = raw_req[SLOT_STX] | stx_req;
        raw_req[SLOT_NMI]        = nmi_req;
        raw_req[SLOT_RESET]      = rpend_q;
    end

    ivc_arbiter u_arb (
        .clk     (clk),
        .rst     (rst),
        .raw_req (raw_req),
        .gie     (gie),
        .grant   (grant)
    );

    assign int_pending = grant.valid & ~halt_q;
    assign int_slot    = grant.slot;
    assign int_vector  = grant.vec;
    assign take_ok     = int_take & int_pending;
    assign wdt_ack     = take_ok & (grant.slot == slot_t'(SLOT_WDT));
    assign irq_ack     = ack_q;
    assign deep_sleep  = halt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rpend_q <= 1'b1;
            halt_q  <= 1'b0;
            ack_q   <= '0;
        end else begin
            if (puc_now)
                rpend_q <= 1'b1;
            else if (take_ok && grant.slot == slot_t'(SLOT_RESET))
                rpend_q <= 1'b0;

            if (rvec_valid && rvec_data == 16'hFFFF)
                halt_q <= 1'b1;
            else if (puc_now)
                halt_q <= 1'b0;

            ack_q <= '0;
            if (take_ok)
                ack_q[grant.slot] <= 1'b1;
        end
    end

    // R7
    ack_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_ack));

    // R7
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (|irq_ack) |-> $past(int_take && int_pending));

    // R9
    puc_clears_en_chk: assert property (@(posedge clk) disable iff (rst)
        sys_reset_req |-> (regs.en1 == 8'h00 && regs.en2 == 8'h00));

    // R10
    low_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        (fetch_valid && fetch_addr < 16'h0200) |=> sys_reset_req);

    // R11
    sleep_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(deep_sleep) |-> $past(rvec_valid && rvec_data == 16'hFFFF));

endmodule

// File: tb/ivc_top_tb_top.sv
module ivc_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        gie = 1'b0;
    logic [29:0] irq_lines = '0;
    logic        wdt_interval = 1'b0, wdt_expire = 1'b0, rst_pin_evt = 1'b0, key_viol = 1'b0;
    logic        nmi_pin_evt = 1'b0, osc_fault_evt = 1'b0, acc_viol = 1'b0;
    logic [3:0]  ser_flag_set = '0;
    logic        fetch_valid = 1'b0;
    logic [15:0] fetch_addr = '0;
    logic        rvec_valid = 1'b0;
    logic [15:0] rvec_data = '0;
    logic [1:0]  reg_addr = '0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic        int_take = 1'b0;
    logic [7:0]  reg_rdata;
    logic        int_pending, sys_reset_req, deep_sleep;
    logic [4:0]  int_slot;
    logic [15:0] int_vector;
    logic [31:0] irq_ack;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    ivc_top dut_i (
        .clk(clk), .rst(rst), .gie(gie), .irq_lines(irq_lines),
        .wdt_interval(wdt_interval), .wdt_expire(wdt_expire), .rst_pin_evt(rst_pin_evt),
        .key_viol(key_viol), .nmi_pin_evt(nmi_pin_evt), .osc_fault_evt(osc_fault_evt),
        .acc_viol(acc_viol), .ser_flag_set(ser_flag_set), .fetch_valid(fetch_valid),
        .fetch_addr(fetch_addr), .rvec_valid(rvec_valid), .rvec_data(rvec_data),
        .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_take(int_take), .int_pending(int_pending), .int_slot(int_slot),
        .int_vector(int_vector), .irq_ack(irq_ack), .sys_reset_req(sys_reset_req),
        .deep_sleep(deep_sleep)
    );

    // reference model state
    logic [7:0]  m_en1, m_en2, m_fl1, m_fl2;
    logic        m_rpend, m_halt, m_srr;
    logic [31:0] m_ack;

    function automatic bit m_bad(input logic v, input logic [15:0] a);
        bit ok;
        ok = (a >= 16'h0200 && a <= 16'h03FF) || (a >= 16'h1000 && a <= 16'h10FF) || (a >= 16'hC000);
        return v && !ok;
    endfunction

    function automatic bit m_elig(input int s);
        case (s)
            31: return m_rpend;
            30: return (m_fl1[4] && m_en1[4]) || (m_fl1[1] && m_en1[1]) || (acc_viol && m_en1[5]);
            26: return gie && (irq_lines[26] || (m_fl1[0] && m_en1[0] && wdt_interval));
            23: return gie && (irq_lines[23] || (m_fl2[0] && m_en2[0]) || (m_fl2[2] && m_en2[2]));
            22: return gie && (irq_lines[22] || (m_fl2[1] && m_en2[1]) || (m_fl2[3] && m_en2[3]));
            default: return gie && irq_lines[s];
        endcase
    endfunction

    function automatic int m_winner();
        for (int s = 31; s >= 0; s--) if (m_elig(s)) return s;
        return -1;
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_en1;
            2'd1: return m_en2;
            2'd2: return m_fl1;
            default: return m_fl2;
        endcase
    endfunction

    always @(posedge clk) begin
        int w;
        bit tk, cause;
        logic [7:0] e1, e2, f1, f2;
        if (rst) begin
            m_en1 = 8'h00; m_en2 = 8'h00; m_fl1 = 8'h06; m_fl2 = 8'h0A;
            m_rpend = 1'b1; m_halt = 1'b0; m_srr = 1'b0; m_ack = '0;
        end else begin
            w = m_winner();
            tk = int_take && (w >= 0) && !m_halt;
            cause = rst_pin_evt || (wdt_expire && !wdt_interval) || key_viol || m_bad(fetch_valid, fetch_addr);
            e1 = m_en1; e2 = m_en2; f1 = m_fl1; f2 = m_fl2;
            if (reg_we) begin
                case (reg_addr)
                    2'd0: e1 = reg_wdata & 8'h33;
                    2'd1: e2 = reg_wdata & 8'h0F;
                    2'd2: f1 = reg_wdata & 8'h1F;
                    default: f2 = reg_wdata & 8'h0F;
                endcase
            end
            if (tk && w == 26) f1[0] = 1'b0;
            if (rst_pin_evt) f1[0] = 1'b0;
            if (wdt_expire || key_viol) f1[0] = 1'b1;
            if (nmi_pin_evt) f1[4] = 1'b1;
            if (osc_fault_evt) f1[1] = 1'b1;
            if (rst_pin_evt) f1[3] = 1'b1;
            f2 = f2 | {4'b0, ser_flag_set};
            if (cause) begin
                e1 = 8'h00; e2 = 8'h00; f1[1] = 1'b1; f2 = 8'h0A | {4'b0, ser_flag_set};
            end
            if (cause) m_rpend = 1'b1;
            else if (tk && w == 31) m_rpend = 1'b0;
            if (rvec_valid && rvec_data == 16'hFFFF) m_halt = 1'b1;
            else if (cause) m_halt = 1'b0;
            m_ack = tk ? (32'd1 << w) : 32'd0;
            m_srr = cause;
            m_en1 = e1; m_en2 = e2; m_fl1 = f1; m_fl2 = f2;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int w;
        bit pend;
        w = m_winner();
        pend = (w >= 0) && !m_halt;
        chk("R2 pending", {31'd0, int_pending}, {31'd0, pend});
        if (pend) begin
            chk("R2 slot", {27'd0, int_slot}, w);
            chk("R2 vector", {16'd0, int_vector}, 32'hFFC0 + 2 * w);
        end
        chk("R7 ack strobe", irq_ack, m_ack);
        chk("R8 read data", {24'd0, reg_rdata}, {24'd0, m_read(reg_addr)});
        chk("R9 restart request", {31'd0, sys_reset_req}, {31'd0, m_srr});
        chk("R11 deep sleep", {31'd0, deep_sleep}, {31'd0, m_halt});
    endtask

    task automatic cyc();
        #1;
        if (!rst) compare_all();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_we = 1'b0;
    endtask

    task automatic take();
        int_take = 1'b1;
        cyc();
        int_take = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end

    logic [15:0] f_addr [12] = '{16'h0000, 16'h01FF, 16'h0200, 16'h03FF, 16'h0400, 16'h0FFF,
                                 16'h1000, 16'h10FF, 16'h1100, 16'hBFFE, 16'hC000, 16'hFFFE};
    logic        f_bad  [12] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1,
                                 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

    initial begin
        @(posedge clk); #2;
        repeat (3) cyc();
        rst = 1'b0;

        // R1 power-up state
        reg_addr = 2'd2; cyc();
        chk("R1 flag1 after power-up", {24'd0, reg_rdata}, 32'h06);
        chk("R1 restart vector pending", {16'd0, int_vector}, 32'hFFFE);
        reg_addr = 2'd3; cyc();
        chk("R1 flag2 after power-up", {24'd0, reg_rdata}, 32'h0A);
        reg_addr = 2'd0; cyc();
        chk("R1 enable1 after power-up", {24'd0, reg_rdata}, 32'h00);

        // R7 take the restart slot
        take();
        chk("R7 restart ack", irq_ack, 32'h8000_0000);
        cyc();
        chk("R7 strobe lasts one cycle", irq_ack, 32'h0);

        // R3 global enable
        gie = 1'b0; irq_lines[18] = 1'b1; cyc();
        chk("R3 masked while gie low", {31'd0, int_pending}, 32'd0);
        gie = 1'b1; cyc();
        chk("R3 port slot vector", {16'd0, int_vector}, 32'hFFE4);
        irq_lines[29] = 1'b1; cyc();
        chk("R2 higher slot wins", {16'd0, int_vector}, 32'hFFFA);
        irq_lines = '0;

        // R6 serial receive via enable2 bit 2
        wr(2'd1, 8'h04);
        ser_flag_set = 4'h4; cyc(); ser_flag_set = 4'h0;
        chk("R6 receive slot vector", {16'd0, int_vector}, 32'hFFEE);
        take();
        chk("R7 receive ack", irq_ack, 32'h0080_0000);
        reg_addr = 2'd3; cyc();
        chk("R7 multi-source flag kept", {24'd0, reg_rdata}, 32'h0E);
        wr(2'd1, 8'h00);

        // R12 set beats write
        reg_we = 1'b1; reg_addr = 2'd3; reg_wdata = 8'h00; ser_flag_set = 4'h1;
        cyc();
        reg_we = 1'b0; ser_flag_set = 4'h0;
        chk("R12 hardware set beats write", {24'd0, reg_rdata}, 32'h01);

        // R8 unimplemented bits, R4 slot 30 ignores gie
        wr(2'd0, 8'hFF);
        chk("R8 enable1 implemented bits", {24'd0, reg_rdata}, 32'h33);
        gie = 1'b0; cyc();
        chk("R4 oscillator fault ignores gie", {16'd0, int_vector}, 32'hFFFC);
        wr(2'd0, 8'h20);
        acc_viol = 1'b1; cyc();
        chk("R4 access violation", {16'd0, int_vector}, 32'hFFFC);
        acc_viol = 1'b0;
        wr(2'd0, 8'h10);
        nmi_pin_evt = 1'b1; cyc(); nmi_pin_evt = 1'b0;
        chk("R12 nmi pin sets flag", {31'd0, int_pending}, 32'd1);
        wr(2'd2, 8'h06);
        wr(2'd0, 8'h00);

        // R5 watchdog interval slot
        gie = 1'b1;
        wr(2'd0, 8'h01);
        wdt_interval = 1'b1; wdt_expire = 1'b1; cyc(); wdt_expire = 1'b0;
        chk("R5 interval watchdog vector", {16'd0, int_vector}, 32'hFFF4);
        wdt_interval = 1'b0; cyc();
        chk("R5 enable ignored in watchdog mode", {31'd0, int_pending}, 32'd0);
        wdt_interval = 1'b1;
        take();
        chk("R7 watchdog ack", irq_ack, 32'h0400_0000);
        reg_addr = 2'd2; cyc();
        chk("R7 single-source flag cleared", {24'd0, reg_rdata}, 32'h06);

        // R9 watchdog-mode expiry restarts
        wr(2'd1, 8'h0F);
        reg_addr = 2'd0;
        wdt_interval = 1'b0; wdt_expire = 1'b1; cyc(); wdt_expire = 1'b0;
        chk("R9 restart request", {31'd0, sys_reset_req}, 32'd1);
        chk("R9 enables cleared", {24'd0, reg_rdata}, 32'h00);
        chk("R9 restart vector", {16'd0, int_vector}, 32'hFFFE);
        take();
        reg_addr = 2'd2;
        rst_pin_evt = 1'b1; cyc(); rst_pin_evt = 1'b0;
        chk("R9 pin restart flags", {24'd0, reg_rdata}, 32'h0E);
        take();

        // R10 fetch ranges
        for (int i = 0; i < 12; i++) begin
            fetch_valid = 1'b1; fetch_addr = f_addr[i];
            cyc();
            chk("R10 illegal fetch decision", {31'd0, sys_reset_req}, {31'd0, f_bad[i]});
        end
        fetch_valid = 1'b0;
        take();

        // R11 erased restart vector
        rvec_valid = 1'b1; rvec_data = 16'h1234; cyc();
        chk("R11 programmed vector no sleep", {31'd0, deep_sleep}, 32'd0);
        rvec_data = 16'hFFFF; cyc(); rvec_valid = 1'b0;
        chk("R11 erased vector sleeps", {31'd0, deep_sleep}, 32'd1);
        irq_lines[18] = 1'b1; cyc();
        chk("R11 no request while asleep", {31'd0, int_pending}, 32'd0);
        key_viol = 1'b1; cyc(); key_viol = 1'b0;
        chk("R11 restart leaves sleep", {31'd0, deep_sleep}, 32'd0);
        irq_lines = '0;
        take();

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            gie           = ($urandom_range(0, 3) != 0);
            irq_lines     = ($urandom_range(0, 2) == 0) ? 30'($urandom) & 30'($urandom) : '0;
            wdt_interval  = ($urandom_range(0, 3) != 0);
            wdt_expire    = ($urandom_range(0, 19) == 0);
            rst_pin_evt   = ($urandom_range(0, 59) == 0);
            key_viol      = ($urandom_range(0, 99) == 0);
            nmi_pin_evt   = ($urandom_range(0, 19) == 0);
            osc_fault_evt = ($urandom_range(0, 29) == 0);
            acc_viol      = ($urandom_range(0, 9) == 0);
            ser_flag_set  = ($urandom_range(0, 4) == 0) ? 4'($urandom) : 4'h0;
            fetch_valid   = ($urandom_range(0, 9) == 0);
            fetch_addr    = 16'($urandom);
            rvec_valid    = ($urandom_range(0, 149) == 0);
            rvec_data     = ($urandom_range(0, 1) == 0) ? 16'hFFFF : 16'($urandom);
            reg_addr      = 2'($urandom);
            reg_we        = ($urandom_range(0, 3) == 0);
            reg_wdata     = 8'($urandom);
            int_take      = ($urandom_range(0, 2) == 0);
            cyc();
        end

        summary();
        $finish;
    end

endmodule